// File: doc/BRIEF.md
# Half-Band Chroma Downsampler (4:4:4 to 4:2:2)

This block takes a stream of 10-bit Y, Cb and Cr pixels that has already been through colour-space conversion. It can produce a 20-bit 4:2:2 stream or a delay-matched 30-bit 4:4:4 stream. In 4:2:2 mode each chroma component goes through a 27-tap half-band low-pass filter and is then kept on alternate pixels only. Cb and Cr share one 10-bit chroma bus, in turn, while Y keeps its full rate. In 4:4:4 mode the three components pass through unfiltered, with the same delay as the filtered path.

The pipeline advances only on cycles where the input valid is high. A pixel's result leaves the block once the 13th later pixel has entered. A flag on the first pixel of each line restarts the Cb/Cr alternation. The same flag marks the line boundaries, and at those boundaries the filter repeats the edge samples instead of reading pixels from the neighbouring line. The tail of a line therefore comes out while the next line is flowing in.

Top module: `ds422_downsampler`

## Requirements
- R1: After reset, `outValid` is low and `outY`, `outC` and `outV` are zero.
- R2: From the 14th valid input pixel onward, every valid input produces `outValid` high exactly two clock cycles later, and never at any other time. That output carries the pixel that entered 13 valid inputs earlier, and its Y value is unchanged.
- R3: With `mode422` low, `outC` and `outV` carry the unfiltered Cb and Cr of that same delayed pixel.
- R4: With `mode422` high, `outV` is zero. `outC` carries filtered Cb on pixels at an even position in the line and filtered Cr on pixels at an odd position. Position 0 is the pixel that arrived with `lineStart` high.
- R5: The filter value for centre pixel p is the sum of w(d)·x(p+d) for d = −13..13, divided by 4096. The weights are w(0)=2048, w(±1)=1283, w(±3)=−383, w(±5)=190, w(±7)=−103, w(±9)=53, w(±11)=−25, w(±13)=9, and 0 for every other even offset.
- R6: A tap that reaches before the first pixel of the centre pixel's line uses that first pixel. A tap that reaches past the centre line's last pixel uses that last pixel. This holds even for lines shorter than the filter span.
- R7: The filter sum has 2048 added, is shifted right arithmetically by 12, and is then clamped to the range 0..1023.
- R8: Chroma that is constant along a line comes out of the filter unchanged.
- R9: Cycles with `inValid` low change neither the filter state nor the outputs that later pixels produce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode422 | input | 1 | 1: 4:2:2 output, 0: 4:4:4 passthrough |
| inValid | input | 1 | Input pixel present this cycle |
| lineStart | input | 1 | Marks the first pixel of a line |
| inY | input | 10 | Luma input |
| inCb | input | 10 | Blue-difference input |
| inCr | input | 10 | Red-difference input |
| outValid | output | 1 | Output pixel present this cycle |
| outY | output | 10 | Delayed luma |
| outC | output | 10 | Cb/Cr interleaved (4:2:2) or Cb (4:4:4) |
| outV | output | 10 | Cr (4:4:4) or zero (4:2:2) |

## Verification
A ramp in 4:4:4 mode shows whether the delay is matched on all three buses. Constant chroma isolates the unity DC gain. A lone spike on Cb at an even position and on Cr at an odd position reads out the filter weights one by one and confirms which component each pixel position selects. A hard step, together with Nyquist-rate alternation, drives the sum past the code range and onto exact half-codes, which exercises clamping and rounding. Lines of one, three and five pixels, valid gaps and random lines show edge repetition and stall immunity that a long uniform line would hide.

// File: rtl/ds422_pkg.sv
package ds422_pkg;

  // Half-band filter geometry: centre tap plus HB_HALF taps each side.
  localparam int HB_HALF   = 13;
  localparam int HB_TAPS   = 2 * HB_HALF + 1;
  localparam int COEF_FRAC = 12;

  // Weight for absolute tap offset k, scaled by 2^COEF_FRAC.
  function automatic int hbCoef(input int k);
    case (k)
      0:       return 2048;
      1:       return 1283;
      3:       return -383;
      5:       return 190;
      7:       return -103;
      9:       return 53;
      11:      return -25;
      13:      return 9;
      default: return 0;
    endcase
  endfunction

  // Strobes from the sequencing logic to the datapath.
  typedef struct packed {
    logic               shiftEn;  // accept a new pixel into the windows
    logic               outEn;    // load the output registers
    logic               phaseCr;  // centre pixel takes the Cr slot
    logic [HB_TAPS-1:0] marks;    // line-start flag per window tap, bit 0 newest
  } dsCtrl_t;

endpackage

// File: rtl/ds422_ctrl.sv
module ds422_ctrl
  import ds422_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    lineStart,
  output dsCtrl_t ctrl
);

  localparam int FILL_MAX = HB_HALF + 1;
  localparam int CNT_W    = $clog2(FILL_MAX + 1);

  logic [HB_TAPS-1:0] markQ;
  logic [CNT_W-1:0]   fillCnt;
  logic               fireQ;
  logic               phaseQ;
  logic               primed;
  logic               curPhase;
  logic               outEn;

  assign primed   = (fillCnt == CNT_W'(FILL_MAX));
  assign outEn    = fireQ && primed;
  assign curPhase = markQ[HB_HALF] ? 1'b0 : phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markQ   <= '0;
      fillCnt <= '0;
      fireQ   <= 1'b0;
      phaseQ  <= 1'b0;
    end else begin
      fireQ <= inValid;
      if (inValid) begin
        markQ <= {markQ[HB_TAPS-2:0], lineStart};
        if (!primed) fillCnt <= fillCnt + 1'b1;
      end
      if (outEn) phaseQ <= ~curPhase;
    end
  end

  always_comb begin
    ctrl.shiftEn = inValid;
    ctrl.outEn   = outEn;
    ctrl.phaseCr = curPhase;
    ctrl.marks   = markQ;
  end

  // R9
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(markQ));

  // R4
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !markQ[HB_HALF]) |=> (phaseQ != $past(phaseQ)));

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(FILL_MAX));

endmodule

// File: rtl/ds422_datapath.sv
module ds422_datapath
  import ds422_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dsCtrl_t           ctrl,
  input  logic              mode422,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outValid,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outC,
  output logic [DATA_W-1:0] outV
);

  localparam int ACC_W = DATA_W + COEF_FRAC + 3;
  localparam int MAXV  = (1 << DATA_W) - 1;

  logic [DATA_W-1:0] yTap  [HB_HALF+1];
  logic [DATA_W-1:0] cbTap [HB_TAPS];
  logic [DATA_W-1:0] crTap [HB_TAPS];
  logic [DATA_W-1:0] win   [HB_TAPS];
  logic [DATA_W-1:0] edgeVal [HB_TAPS];
  logic signed [ACC_W-1:0] acc, tapSum, coefS, rnd;
  logic [DATA_W-1:0] filtOut;
  logic              modeQ;

  // Delay lines, advancing only on accepted pixels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= HB_HALF; i++) yTap[i] <= '0;
      for (int i = 0; i < HB_TAPS; i++) begin
        cbTap[i] <= '0;
        crTap[i] <= '0;
      end
    end else if (ctrl.shiftEn) begin
      yTap[0]  <= inY;
      cbTap[0] <= inCb;
      crTap[0] <= inCr;
      for (int i = 1; i <= HB_HALF; i++) yTap[i] <= yTap[i-1];
      for (int i = 1; i < HB_TAPS; i++) begin
        cbTap[i] <= cbTap[i-1];
        crTap[i] <= crTap[i-1];
      end
    end
  end

  // One shared filter: pick the component that owns this pixel slot.
  always_comb begin
    for (int i = 0; i < HB_TAPS; i++)
      win[i] = ctrl.phaseCr ? crTap[i] : cbTap[i];
  end

  // Edge repetition: older taps stop at the line's first pixel, newer taps
  // stop at the line's last pixel.
  always_comb begin
    logic stopOld, stopNew;
    stopOld = 1'b0;
    stopNew = 1'b0;
    edgeVal[HB_HALF] = win[HB_HALF];
    for (int j = HB_HALF + 1; j < HB_TAPS; j++) begin
      stopOld    = stopOld | ctrl.marks[j-1];
      edgeVal[j] = stopOld ? edgeVal[j-1] : win[j];
    end
    for (int j = HB_HALF - 1; j >= 0; j--) begin
      stopNew    = stopNew | ctrl.marks[j];
      edgeVal[j] = stopNew ? edgeVal[j+1] : win[j];
    end
  end

  // Symmetric multiply-accumulate over the non-zero taps.
  always_comb begin
    coefS  = ACC_W'(hbCoef(0));
    tapSum = signed'(ACC_W'(edgeVal[HB_HALF]));
    acc    = coefS * tapSum;
    for (int k = 1; k <= HB_HALF; k += 2) begin
      tapSum = signed'(ACC_W'(edgeVal[HB_HALF-k])) + signed'(ACC_W'(edgeVal[HB_HALF+k]));
      coefS  = ACC_W'(hbCoef(k));
      acc    = acc + coefS * tapSum;
    end
    rnd = (acc + ACC_W'(1 <<< (COEF_FRAC - 1))) >>> COEF_FRAC;
    if (rnd < 0)
      filtOut = '0;
    else if (rnd > ACC_W'(MAXV))
      filtOut = DATA_W'(MAXV);
    else
      filtOut = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outY     <= '0;
      outC     <= '0;
      outV     <= '0;
      modeQ    <= 1'b0;
    end else begin
      outValid <= ctrl.outEn;
      if (ctrl.outEn) begin
        modeQ <= mode422;
        outY  <= yTap[HB_HALF];
        outC  <= mode422 ? filtOut : cbTap[HB_HALF];
        outV  <= mode422 ? '0 : crTap[HB_HALF];
      end
    end
  end

  // R4
  third_bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && modeQ) |-> (outV == '0));

endmodule

// File: rtl/ds422_downsampler.sv
module ds422_downsampler
  import ds422_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode422,
  input  logic              inValid,
  input  logic              lineStart,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outValid,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outC,
  output logic [DATA_W-1:0] outV
);

  dsCtrl_t ctrl;

  ds422_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .lineStart (lineStart),
    .ctrl      (ctrl)
  );

  ds422_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .mode422  (mode422),
    .inY      (inY),
    .inCb     (inCb),
    .inCr     (inCr),
    .outValid (outValid),
    .outY     (outY),
    .outC     (outC),
    .outV     (outV)
  );

  // R2
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

endmodule

// File: tb/ds422_downsampler_tb.sv
`timescale 1ns/1ps
module ds422_downsampler_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode422 = 1'b0;
  logic inValid = 1'b0;
  logic lineStart = 1'b0;
  logic [9:0] inY = '0, inCb = '0, inCr = '0;
  logic outValid;
  logic [9:0] outY, outC, outV;

  always #2.5 clk = ~clk;

  ds422_downsampler u_dut (
    .clk(clk), .rstN(rstN), .mode422(mode422), .inValid(inValid),
    .lineStart(lineStart), .inY(inY), .inCb(inCb), .inCr(inCr),
    .outValid(outValid), .outY(outY), .outC(outC), .outV(outV)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curReq = "R3";

  int gY[$], gCb[$], gCr[$], gLine[$], gPos[$], lineFirst[$];
  int expY[$], expC[$], expV[$];
  string expR[$];
  bit h0 = 0, h1 = 0;

  function automatic int weight(int k);
    int a = (k < 0) ? -k : k;
    case (a)
      0: return 2048;  1: return 1283;  3: return -383; 5: return 190;
      7: return -103;  9: return 53;    11: return -25; 13: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic int clampIdx(int p, int i);
    int lp = gLine[p];
    if (i < lineFirst[lp]) return lineFirst[lp];
    if (i > p && gLine[i] != lp) return lineFirst[lp+1] - 1;
    return i;
  endfunction

  function automatic int chromaRef(int p);
    int acc = 0;
    int r;
    bit odd = gPos[p] % 2;
    for (int d = -13; d <= 13; d++) begin
      int idx = clampIdx(p, p + d);
      acc += weight(d) * (odd ? gCr[idx] : gCb[idx]);
    end
    r = (acc + 2048) >>> 12;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit ls, int y, int cb, int cr);
    @(negedge clk);
    check("R2", int'(outValid), int'(h1));
    if (outValid) begin
      if (expY.size() == 0) begin
        check("R2", 1, 0);
      end else begin
        string r = expR.pop_front();
        check("R2", int'(outY), expY.pop_front());
        check(r, int'(outC), expC.pop_front());
        check(r, int'(outV), expV.pop_front());
      end
    end
    h1 = h0;
    h0 = 0;
    inValid = v; lineStart = ls;
    inY = 10'(y); inCb = 10'(cb); inCr = 10'(cr);
    if (v) begin
      int q;
      if (ls) begin
        lineFirst.push_back(gY.size());
        gPos.push_back(0);
      end else begin
        gPos.push_back(gPos[$] + 1);
      end
      gLine.push_back(lineFirst.size() - 1);
      gY.push_back(y); gCb.push_back(cb); gCr.push_back(cr);
      q = gY.size() - 1;
      if (q >= 13) begin
        int p = q - 13;
        h0 = 1;
        expY.push_back(gY[p]);
        if (mode422) begin
          expC.push_back(chromaRef(p));
          expV.push_back(0);
        end else begin
          expC.push_back(gCb[p]);
          expV.push_back(gCr[p]);
        end
        expR.push_back(curReq);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic randLine(int len);
    for (int i = 0; i < len; i++)
      step(1, i == 0, $urandom_range(1023), $urandom_range(1023), $urandom_range(1023));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(outValid), 0);
    check("R1", int'(outY), 0);
    check("R1", int'(outC), 0);
    check("R1", int'(outV), 0);
    rstN = 1'b1;

    // R3: passthrough ramp
    curReq = "R3"; mode422 = 0;
    for (int i = 0; i < 40; i++) step(1, i == 0, i * 7, (i * 11) % 1024, 1023 - i * 5);
    idle(3);

    // R8: constant chroma
    mode422 = 1; curReq = "R8";
    for (int i = 0; i < 40; i++) step(1, i == 0, i, 300, 700);

    // R5: isolated spikes on Cb (even slot) and Cr (odd slot)
    curReq = "R5";
    for (int i = 0; i < 40; i++)
      step(1, i == 0, 1000 - i, (i == 20) ? 1000 : 512, (i == 21) ? 100 : 512);

    // R7: hard step and Nyquist alternation
    curReq = "R7";
    for (int i = 0; i < 40; i++)
      step(1, i == 0, i, (i < 20) ? 0 : 1023, (i % 2) ? 1023 : 0);

    // R6: lines shorter than the filter span
    curReq = "R6";
    randLine(5); randLine(1); randLine(3); randLine(20);

    // R9: valid gaps inside a line
    curReq = "R9";
    for (int i = 0; i < 30; i++) begin
      step(1, i == 0, $urandom_range(1023), $urandom_range(1023), $urandom_range(1023));
      if (i % 3 == 1) idle(1 + i % 2);
    end

    // R4: random lines, slot alternation restarting per line
    curReq = "R4";
    randLine(33); randLine(34); randLine(14);
    idle(3);

    // R3: back to passthrough after filtering
    mode422 = 0; curReq = "R3";
    randLine(17); randLine(14);
    idle(4);
    check("R2", expY.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule